// File: doc/BRIEF.md
# Two-Step Refresh Watchdog Timer

This block is a free-running 16-bit supervision counter. Once started it counts up at a fixed fraction of the system clock. When it lands on the terminal value 7CFFh it raises a reset request, which the device reset logic consumes. Software keeps the device alive by servicing the counter with two register writes in a row. The first write arms a short window. The second write, a confirm, must land inside that window. Together they reload the upper part of the counter from a software-written reload byte. Because a refresh needs two writes in order, a single stray write cannot keep a crashed program alive.

The counter can be started in two ways. A strap sampled while reset is held can start it automatically. Otherwise software starts it later with a confirm write. Once running, only reset stops it. Bit 7 of the reload byte slows the count by an extra prescale factor. Bits 6:0 of the reload byte supply counter bits 14:8 on a refresh.

The request flag is also the value software reads back at the bit position it writes to confirm.

Top module: `refresh_watchdog`

## Requirements
- R1: While running with reload bit 7 at 0, the counter advances by exactly one every BASE_DIV clocks and by no other step.
- R2: With reload bit 7 at 1, the counter advances once every BASE_DIV*EXTRA_DIV clocks.
- R3: Reset clears the counter, the prescaler, the reload byte (bit 7 included) and the arm window, and drives req_o low.
- R4: If autostart_i is high on the last clock edge of reset, the counter runs from zero immediately after reset. req_o then rises 31999 ticks later.
- R5: Without the strap the counter holds its value until a confirm write starts it. Counting then begins on the next tick.
- R6: Once running, the counter keeps running through any sequence of writes; only reset stops it.
- R7: req_o is high exactly while the counter equals 7CFFh. It rises on the tick that reaches 7CFFh and falls on the next counter change.
- R8: A confirm write on any of the 12 clock edges after an arm write's edge performs a refresh. It loads bits 14:8 from reload bits 6:0 and clears bit 15 and bits 7:0, clears the prescaler, and starts a stopped counter.
- R9: The arm window closes by itself after 12 cycles, so a confirm on the 13th edge or later does no refresh. A refresh also consumes the arm.
- R10: A confirm write with no open arm window never reloads the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Internal synchronous reset, active high |
| autostart_i | input | 1 | Auto-start strap, sampled only while rst is high |
| arm_wr_i | input | 1 | One-cycle strobe: software sets the arm bit |
| confirm_wr_i | input | 1 | One-cycle strobe: software sets the confirm/start bit |
| reload_wr_i | input | 1 | One-cycle strobe: write reload_i to the reload byte |
| reload_i | input | RLD_W | Reload byte data: bit 7 selects slow prescale, bits 6:0 feed counter bits 14:8 |
| req_o | output | 1 | Reset request and status flag; also the read value of the confirm bit position |

## Verification
The bench builds the block with BASE_DIV=1, EXTRA_DIV=4 and WIN=12, keeping the 16-bit counter and the fixed 7CFFh terminal value. With one tick per clock, the full climb from zero to the terminal value takes 31999 cycles. That makes the auto-start and late-start paths checkable to the exact cycle. The window keeps its real width of 12, so confirms on the 12th and 13th edges after an arm probe both sides of the window. An extra factor of 4 gives a slow-prescale expiry that differs clearly from the base-rate one. It also shows whether reset cleared reload bit 7.

// File: rtl/rwd_pkg.sv
package rwd_pkg;

   // Default shape of the watchdog
   localparam int unsigned DFLT_CNT_W     = 16;
   localparam int unsigned DFLT_RLD_W     = 8;
   localparam int unsigned DFLT_BASE_DIV  = 24;
   localparam int unsigned DFLT_EXTRA_DIV = 16;
   localparam int unsigned DFLT_WIN       = 12;

   // Bits needed to hold values 0 .. n-1 (at least one bit)
   function automatic int unsigned bits_for(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rwd_prescale.sv
module rwd_prescale #(
   parameter int unsigned BASE_DIV  = rwd_pkg::DFLT_BASE_DIV,
   parameter int unsigned EXTRA_DIV = rwd_pkg::DFLT_EXTRA_DIV
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   input  logic clear_i,
   input  logic slow_i,
   output logic tick_o
);
   localparam int unsigned MAX_DIV = BASE_DIV * EXTRA_DIV;
   localparam int unsigned PW      = rwd_pkg::bits_for(MAX_DIV);
   localparam logic [PW-1:0] BASE_LAST = PW'(BASE_DIV - 1);
   localparam logic [PW-1:0] SLOW_LAST = PW'(MAX_DIV - 1);

   logic [PW-1:0] pre_q;
   logic [PW-1:0] last;

   generate
      if (EXTRA_DIV > 1) begin : g_two_rate
         assign last = slow_i ? SLOW_LAST : BASE_LAST;
      end else begin : g_one_rate
         assign last = BASE_LAST;
      end
   endgenerate

   // ">=" so that a rate change mid-count never strands the prescaler
   assign tick_o = run_i && (pre_q >= last);

   always_ff @(posedge clk) begin
      if (rst) begin
         pre_q <= '0;
      end else if (clear_i || tick_o) begin
         pre_q <= '0;
      end else if (run_i) begin
         pre_q <= pre_q + 1'b1;
      end
   end

endmodule

// File: rtl/rwd_window.sv
module rwd_window #(
   parameter int unsigned WIN = rwd_pkg::DFLT_WIN,
   localparam int unsigned AW = rwd_pkg::bits_for(WIN)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          set_i,
   input  logic          consume_i,
   output logic          live_o,
   output logic [AW-1:0] age_o
);
   localparam logic [AW-1:0] AGE_LAST = AW'(WIN - 1);

   logic          live_q;
   logic [AW-1:0] age_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         live_q <= 1'b0;
         age_q  <= '0;
      end else if (set_i) begin
         live_q <= 1'b1;
         age_q  <= '0;
      end else if (consume_i) begin
         live_q <= 1'b0;
         age_q  <= '0;
      end else if (live_q) begin
         if (age_q == AGE_LAST) begin
            live_q <= 1'b0;
            age_q  <= '0;
         end else begin
            age_q <= age_q + 1'b1;
         end
      end
   end

   assign live_o = live_q;
   assign age_o  = age_q;

endmodule

// File: rtl/rwd_counter.sv
module rwd_counter #(
   parameter int unsigned CNT_W = rwd_pkg::DFLT_CNT_W,
   parameter int unsigned RLD_W = rwd_pkg::DFLT_RLD_W,
   parameter logic [CNT_W-1:0] EXPIRE_AT = 'h7CFF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [RLD_W-2:0] seed_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   // Seed lands just below the top bit; top bit and low part are zero
   always_comb begin
      load_val = '0;
      load_val[CNT_W-2 -: (RLD_W-1)] = seed_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign hit_o = (cnt_q == EXPIRE_AT);

endmodule

// File: rtl/refresh_watchdog.sv
module refresh_watchdog #(
   parameter int unsigned CNT_W     = rwd_pkg::DFLT_CNT_W,
   parameter int unsigned RLD_W     = rwd_pkg::DFLT_RLD_W,
   parameter int unsigned BASE_DIV  = rwd_pkg::DFLT_BASE_DIV,
   parameter int unsigned EXTRA_DIV = rwd_pkg::DFLT_EXTRA_DIV,
   parameter int unsigned WIN       = rwd_pkg::DFLT_WIN,
   parameter logic [CNT_W-1:0] EXPIRE_AT = 'h7CFF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             autostart_i,
   input  logic             arm_wr_i,
   input  logic             confirm_wr_i,
   input  logic             reload_wr_i,
   input  logic [RLD_W-1:0] reload_i,
   output logic             req_o
);
   localparam int unsigned ARM_AW = rwd_pkg::bits_for(WIN);

   generate
      if (CNT_W <= RLD_W) begin : g_bad_width
         $error("refresh_watchdog: CNT_W must be wider than RLD_W");
      end
      if (RLD_W < 2) begin : g_bad_reload
         $error("refresh_watchdog: RLD_W must be at least 2");
      end
      if (BASE_DIV < 1 || EXTRA_DIV < 1) begin : g_bad_div
         $error("refresh_watchdog: divider factors must be at least 1");
      end
      if (WIN < 1) begin : g_bad_win
         $error("refresh_watchdog: WIN must be at least 1");
      end
   endgenerate

   logic [RLD_W-1:0]  reload_q;
   logic              run_q;
   logic              arm_live;
   logic [ARM_AW-1:0] arm_age;
   logic              refresh;
   logic              tick;
   logic [CNT_W-1:0]  cnt;
   logic              hit;

   // A confirm counts as a refresh only inside an open arm window
   assign refresh = confirm_wr_i && arm_live;

   always_ff @(posedge clk) begin
      if (rst) begin
         reload_q <= '0;
         run_q    <= autostart_i;
      end else begin
         if (reload_wr_i) reload_q <= reload_i;
         if (confirm_wr_i) run_q <= 1'b1;
      end
   end

   rwd_window #(.WIN(WIN)) u_arm (
      .clk       (clk),
      .rst       (rst),
      .set_i     (arm_wr_i),
      .consume_i (refresh),
      .live_o    (arm_live),
      .age_o     (arm_age)
   );

   rwd_prescale #(.BASE_DIV(BASE_DIV), .EXTRA_DIV(EXTRA_DIV)) u_pre (
      .clk     (clk),
      .rst     (rst),
      .run_i   (run_q),
      .clear_i (refresh),
      .slow_i  (reload_q[RLD_W-1]),
      .tick_o  (tick)
   );

   rwd_counter #(.CNT_W(CNT_W), .RLD_W(RLD_W), .EXPIRE_AT(EXPIRE_AT)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick),
      .load_i (refresh),
      .seed_i (reload_q[RLD_W-2:0]),
      .cnt_o  (cnt),
      .hit_o  (hit)
   );

   assign req_o = hit;

endmodule

module refresh_watchdog_chk #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned WIN   = 12,
   parameter int unsigned AGE_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             confirm_wr_i,
   input logic             arm_live,
   input logic [AGE_W-1:0] arm_age,
   input logic             run_q,
   input logic             refresh,
   input logic [CNT_W-1:0] cnt,
   input logic             req_o
);
   // R1: without a refresh the counter holds or steps by one
   a_r1_step_by_one: assert property (@(posedge clk) disable iff (rst)
      !refresh |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

   // R5: a stopped counter with no refresh keeps its value
   a_r5_stopped_frozen: assert property (@(posedge clk) disable iff (rst)
      (!run_q && !refresh) |=> $stable(cnt));

   // R6: running never drops outside reset
   a_r6_run_sticky: assert property (@(posedge clk) disable iff (rst)
      run_q |=> run_q);

   // R7: the request only falls together with a counter change
   a_r7_req_falls_on_change: assert property (@(posedge clk) disable iff (rst)
      req_o |=> (req_o || cnt != $past(cnt)));

   // R9: the arm window never outlives WIN cycles
   a_r9_window_bounded: assert property (@(posedge clk) disable iff (rst)
      arm_live |-> (arm_age < AGE_W'(WIN)));

   // R10: a confirm with no open window does not reload
   a_r10_lone_confirm_no_load: assert property (@(posedge clk) disable iff (rst)
      (confirm_wr_i && !arm_live) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

endmodule

bind refresh_watchdog refresh_watchdog_chk #(
   .CNT_W (CNT_W),
   .WIN   (WIN),
   .AGE_W (ARM_AW)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .confirm_wr_i (confirm_wr_i),
   .arm_live     (arm_live),
   .arm_age      (arm_age),
   .run_q        (run_q),
   .refresh      (refresh),
   .cnt          (cnt),
   .req_o        (req_o)
);

// File: tb/refresh_watchdog_test.sv
module refresh_watchdog_test;
   localparam int CLK_PERIOD = 10;
   localparam int RLD_W      = 8;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             autostart_i = 1'b0;
   logic             arm_wr_i = 1'b0;
   logic             confirm_wr_i = 1'b0;
   logic             reload_wr_i = 1'b0;
   logic [RLD_W-1:0] reload_i = '0;
   logic             req_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   refresh_watchdog #(
      .CNT_W (16), .RLD_W (RLD_W), .BASE_DIV (1), .EXTRA_DIV (4), .WIN (12),
      .EXPIRE_AT (16'h7CFF)
   ) uut (
      .clk          (clk),
      .rst          (rst),
      .autostart_i  (autostart_i),
      .arm_wr_i     (arm_wr_i),
      .confirm_wr_i (confirm_wr_i),
      .reload_wr_i  (reload_wr_i),
      .reload_i     (reload_i),
      .req_o        (req_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input logic exp, input string tag);
      n_cmp++;
      if (req_o !== exp) begin
         n_bad++;
         $display("FAIL %s: req_o=%0b expected %0b", tag, req_o, exp);
      end
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      rst = 1'b1;
      autostart_i = strap;
      step(3);
      rst = 1'b0;
      autostart_i = 1'b0;
   endtask

   task automatic pulse_arm();
      arm_wr_i = 1'b1;
      step(1);
      arm_wr_i = 1'b0;
   endtask

   task automatic pulse_confirm();
      confirm_wr_i = 1'b1;
      step(1);
      confirm_wr_i = 1'b0;
   endtask

   task automatic write_reload(input logic [RLD_W-1:0] v);
      reload_i = v;
      reload_wr_i = 1'b1;
      step(1);
      reload_wr_i = 1'b0;
   endtask

   task automatic t_reset();
      do_reset(1'b0);
      check(1'b0, "R3 request low out of reset");
      step(40);
      check(1'b0, "R3 stopped counter raises no request");
   endtask

   task automatic t_refresh_basic();
      write_reload(8'h7C);
      pulse_arm();
      pulse_confirm();          // refresh edge E, counter 7C00
      step(1);
      pulse_confirm();          // E+2: arm already consumed
      step(252);
      check(1'b0, "R1 R8 no request one tick before 7CFF");
      step(1);
      check(1'b1, "R7 R8 R10 request at 7CFF, second confirm ignored");
      step(1);
      check(1'b0, "R7 request drops on next counter change");
   endtask

   task automatic t_window();
      pulse_arm();              // A
      step(11);
      pulse_confirm();          // edge A+12: last legal edge, E
      step(10);
      pulse_arm();              // E+11
      step(12);
      pulse_confirm();          // 13 edges after arm: stale
      step(230);
      check(1'b0, "R9 no request before expiry");
      step(1);
      check(1'b1, "R9 confirm on 12th edge accepted, 13th rejected");
      step(1);
      check(1'b0, "R7 request low after counter moves on");
   endtask

   task automatic t_reload_alt();
      write_reload(8'h7A);
      pulse_arm();
      pulse_confirm();          // counter 7A00
      step(766);
      check(1'b0, "R8 reload 7A: low one tick early");
      step(1);
      check(1'b1, "R8 reload 7A: request after 767 ticks");
      step(1);
      check(1'b0, "R7 reload 7A: request falls");
   endtask

   task automatic t_prescale();
      write_reload(8'hFC);
      pulse_arm();
      pulse_confirm();          // counter 7C00, bit 15 cleared
      step(1019);
      check(1'b0, "R2 slow rate: low before 255 slow ticks");
      step(1);
      check(1'b1, "R2 R8 slow rate: request after 1020 clocks");
      step(3);
      check(1'b1, "R2 request held for one slow tick period");
      step(1);
      check(1'b0, "R2 R7 request falls on next slow tick");
   endtask

   task automatic t_autostart();
      do_reset(1'b1);           // last reset edge L
      check(1'b0, "R3 request low after reset with strap");
      step(31998);
      check(1'b0, "R4 auto-started counter not yet at 7CFF");
      step(1);
      check(1'b1, "R3 R4 auto-start at base rate reaches 7CFF");
      step(1);
      check(1'b0, "R7 auto-start request falls");
   endtask

   task automatic t_late_start();
      do_reset(1'b0);
      step(20);
      pulse_confirm();          // start edge S, counter 0
      step(100);
      pulse_confirm();          // S+101, lone confirm while running
      step(50);
      pulse_arm();              // S+152
      step(13);
      pulse_confirm();          // S+166, window closed
      step(31832);
      check(1'b0, "R5 R6 R10 low one tick before expiry");
      step(1);
      check(1'b1, "R5 R6 R10 started by confirm, never reloaded");
      step(1);
      check(1'b0, "R7 late-start request falls");
   endtask

   initial begin
      t_reset();
      t_refresh_basic();
      t_window();
      t_reload_alt();
      t_prescale();
      t_autostart();
      t_late_start();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule